// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a watchdog for a system-on-chip. It runs on the system clock. A 256 Hz tick strobe, taken from a slow oscillator outside the block, advances it. A 12-bit counter moves down by one on each tick. Software keeps the system alive by writing a keyed restart command, which reloads the counter. If the counter runs out, the block records an underflow fault. If software restarts while the counter is still above a configured delta, the block records a window fault. A restart that comes too early is therefore also an error.

One mode register sets the configuration. It holds the reload value, the delta, a fault-interrupt enable, a reset enable, a reset-scope select, a disable bit, and two halt controls. The first write after reset locks this register, so the configuration cannot be changed afterwards. A status register keeps the fault flags until software reads it. The flags drive an interrupt line and one of two reset-request lines. One line asks for a processor-only reset and the other asks for a full-system reset.

Registers are reached by word index over a simple single-cycle bus. Read data is combinational in the same cycle as the read.

Top module: `wdog_win_top`

## Requirements
- R1: After reset, the mode register (index 1) reads 0x3FFF2FFF. The status register (index 2) reads 0 and all three fault outputs are low. The mode fields are:
  - reload in [11:0]
  - fault-interrupt enable in bit 12
  - reset enable in bit 13
  - reset scope in bit 14 (1 = processor only)
  - disable in bit 15
  - delta in [27:16]
  - debug-halt enable in bit 28
  - idle-halt enable in bit 29
- R2: Only the first write to the mode register after reset takes effect. Every later write leaves its contents unchanged.
- R3: When the block is running, each tick lowers the counter by one. A tick that arrives while the counter is 0 sets status bit 0 (underflow) and reloads the counter from the reload field.
- R4: A write to the control register (index 0) with 0xA5 in bits [31:24] and bit 0 set is a restart, and it reloads the counter. A control write with any other key, or with bit 0 clear, has no effect.
- R5: A restart while the counter is strictly greater than delta sets status bit 1 (window error) and still reloads the counter. A restart with the counter equal to or below delta raises no error.
- R6: The interrupt output equals fault-interrupt enable AND any status flag set. When reset enable is set and a flag is set, exactly one reset request is raised, chosen by the scope bit.
- R7: A status read returns both flags and clears them at the end of the cycle. A fault event in the same cycle as the read sets its flag anyway.
- R8: The counter holds its value on ticks while the idle input is high with idle-halt enabled, and likewise while the debug input is high with debug-halt enabled.
- R9: While the disable bit is set, the counter never faults and restart commands are ignored.
- R10: A status flag stays set, and so do the outputs it drives, until the status register is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle strobe at 256 Hz |
| bus_sel_i | input | 1 | Bus access valid this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_idx_i | input | 2 | Register index: 0 control, 1 mode, 2 status |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| idle_i | input | 1 | System idle indication |
| dbg_i | input | 1 | Debugger halt indication |
| fault_irq_o | output | 1 | Fault interrupt |
| rst_proc_o | output | 1 | Processor-only reset request |
| rst_sys_o | output | 1 | Full-system reset request |

## Verification
The assertions check the following on every cycle:
- the mode register stays frozen once locked;
- a restart loads the reload value;
- a halted or disabled counter stays still;
- each fault event lands in its flag;
- a flag stays set until a read clears it.

Some behaviour only the bench scenarios can show: the exact tick on which an underflow happens, the boundary where a restart at the delta is accepted, ignored wrong-key commands, and the race between a read and an event in the same cycle. The bench compares these against a behavioural model on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned WD_CNT_W  = 12;
    localparam int unsigned WD_DATA_W = 32;
    localparam logic [7:0]  WD_KEY    = 8'hA5;
    localparam logic [31:0] MODE_RST  = 32'h3FFF2FFF;

    typedef struct packed {
        logic [1:0]          spare;
        logic                idle_halt;
        logic                dbg_halt;
        logic [WD_CNT_W-1:0] delta;
        logic                wd_off;
        logic                scope_proc;
        logic                rst_en;
        logic                fault_ie;
        logic [WD_CNT_W-1:0] reload;
    } mode_t;

    typedef enum logic [1:0] {
        IDX_CTRL = 2'd0,
        IDX_MODE = 2'd1,
        IDX_STAT = 2'd2,
        IDX_NONE = 2'd3
    } reg_idx_e;

    function automatic logic is_restart(input logic [WD_DATA_W-1:0] d);
        return (d[31:24] == WD_KEY) && d[0];
    endfunction

endpackage

// File: rtl/wdog_mode_reg.sv
module wdog_mode_reg
    import wdog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [WD_DATA_W-1:0] wdata,
    output mode_t                mode,
    output logic                 locked
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= mode_t'(MODE_RST);
            locked <= 1'b0;
        end else if (wr_en && !locked) begin
            mode   <= mode_t'(wdata);
            locked <= 1'b1;
        end
    end

    // R2
    mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(mode) && locked));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = WD_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] delta,
    input  logic             wd_off,
    input  logic             idle_halt,
    input  logic             dbg_halt,
    input  logic             idle_in,
    input  logic             dbg_in,
    output logic             uf_evt,
    output logic             win_evt
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic             run;
    logic             restart_ok;

    always_comb begin
        run        = !wd_off && !(idle_halt && idle_in) && !(dbg_halt && dbg_in);
        restart_ok = restart && !wd_off;
        win_evt    = restart_ok && (cnt > delta);
        uf_evt     = !restart_ok && run && tick && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CNT_TOP;
        end else if (restart_ok) begin
            cnt <= reload;
        end else if (run && tick) begin
            cnt <= (cnt == '0) ? reload : cnt - 1'b1;
        end
    end

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        restart_ok |=> (cnt == $past(reload)));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart_ok && !run) |=> $stable(cnt));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart_ok && run && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/wdog_status.sv
module wdog_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       uf_evt,
    input  logic       win_evt,
    input  logic       rd_clr,
    input  logic       fault_ie,
    input  logic       rst_en,
    input  logic       scope_proc,
    output logic [1:0] flags,
    output logic       irq,
    output logic       rst_proc,
    output logic       rst_sys
);

    logic fault;

    always_ff @(posedge clk) begin
        if (rst) flags <= 2'b00;
        else     flags <= (flags & {2{!rd_clr}}) | {win_evt, uf_evt};
    end

    always_comb begin
        fault    = |flags;
        irq      = fault && fault_ie;
        rst_proc = fault && rst_en && scope_proc;
        rst_sys  = fault && rst_en && !scope_proc;
    end

    // R3
    uf_flag_chk: assert property (@(posedge clk) disable iff (rst)
        uf_evt |=> flags[0]);

    // R5
    win_flag_chk: assert property (@(posedge clk) disable iff (rst)
        win_evt |=> flags[1]);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !uf_evt && !win_evt) |=> (flags == 2'b00));

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_clr && flags != 2'b00) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/wdog_win_top.sv
module wdog_win_top
    import wdog_pkg::*;
#(
    parameter int unsigned DATA_W = WD_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [1:0]        bus_idx_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              idle_i,
    input  logic              dbg_i,
    output logic              fault_irq_o,
    output logic              rst_proc_o,
    output logic              rst_sys_o
);

    reg_idx_e   idx;
    mode_t      mode;
    logic       locked;
    logic       mode_wr;
    logic       restart;
    logic       rd_clr;
    logic       uf_evt;
    logic       win_evt;
    logic [1:0] flags;

    always_comb begin
        idx     = reg_idx_e'(bus_idx_i);
        mode_wr = bus_sel_i && bus_we_i && (idx == IDX_MODE);
        restart = bus_sel_i && bus_we_i && (idx == IDX_CTRL) && is_restart(bus_wdata_i);
        rd_clr  = bus_sel_i && !bus_we_i && (idx == IDX_STAT);
    end

    wdog_mode_reg u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (mode_wr),
        .wdata  (bus_wdata_i),
        .mode   (mode),
        .locked (locked)
    );

    wdog_counter #(.CNT_W(WD_CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_i),
        .restart   (restart),
        .reload    (mode.reload),
        .delta     (mode.delta),
        .wd_off    (mode.wd_off),
        .idle_halt (mode.idle_halt),
        .dbg_halt  (mode.dbg_halt),
        .idle_in   (idle_i),
        .dbg_in    (dbg_i),
        .uf_evt    (uf_evt),
        .win_evt   (win_evt)
    );

    wdog_status u_stat (
        .clk        (clk),
        .rst        (rst),
        .uf_evt     (uf_evt),
        .win_evt    (win_evt),
        .rd_clr     (rd_clr),
        .fault_ie   (mode.fault_ie),
        .rst_en     (mode.rst_en),
        .scope_proc (mode.scope_proc),
        .flags      (flags),
        .irq        (fault_irq_o),
        .rst_proc   (rst_proc_o),
        .rst_sys    (rst_sys_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_sel_i && !bus_we_i) begin
            case (idx)
                IDX_MODE: bus_rdata_o = DATA_W'(mode);
                IDX_STAT: bus_rdata_o = {{(DATA_W-2){1'b0}}, flags};
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mode.wd_off |-> (!uf_evt && !win_evt));

    // R6
    one_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({rst_proc_o, rst_sys_o}) <= 1);

    // R2
    lock_set_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> locked);

endmodule

// File: tb/wdog_win_top_tb_top.sv
module wdog_win_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        bus_sel_i = 1'b0;
    logic        bus_we_i = 1'b0;
    logic [1:0]  bus_idx_i = 2'd0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        idle_i = 1'b0;
    logic        dbg_i = 1'b0;
    logic        fault_irq_o;
    logic        rst_proc_o;
    logic        rst_sys_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference model
    logic [31:0] m_mode;
    bit          m_lock;
    int          m_cnt;
    bit          m_uf;
    bit          m_win;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_win_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .tick_i      (tick_i),
        .bus_sel_i   (bus_sel_i),
        .bus_we_i    (bus_we_i),
        .bus_idx_i   (bus_idx_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .idle_i      (idle_i),
        .dbg_i       (dbg_i),
        .fault_irq_o (fault_irq_o),
        .rst_proc_o  (rst_proc_o),
        .rst_sys_o   (rst_sys_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 32'h3FFF2FFF;
            m_lock = 0;
            m_cnt  = 4095;
            m_uf   = 0;
            m_win  = 0;
        end else begin
            bit off, run, rs, rd, uf, win;
            int reload, delta;
            reload = int'(m_mode[11:0]);
            delta  = int'(m_mode[27:16]);
            off = m_mode[15];
            run = !off && !(m_mode[29] && idle_i) && !(m_mode[28] && dbg_i);
            rs  = bus_sel_i && bus_we_i && bus_idx_i == 2'd0 &&
                  bus_wdata_i[31:24] == 8'hA5 && bus_wdata_i[0] && !off;
            rd  = bus_sel_i && !bus_we_i && bus_idx_i == 2'd2;
            uf = 0;
            win = 0;
            if (rs) begin
                win = m_cnt > delta;
                m_cnt = reload;
            end else if (run && tick_i) begin
                if (m_cnt == 0) begin
                    uf = 1;
                    m_cnt = reload;
                end else begin
                    m_cnt = m_cnt - 1;
                end
            end
            if (rd) begin
                m_uf = 0;
                m_win = 0;
            end
            if (uf) m_uf = 1;
            if (win) m_win = 1;
            if (bus_sel_i && bus_we_i && bus_idx_i == 2'd1 && !m_lock) begin
                m_mode = bus_wdata_i;
                m_lock = 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // R6 R10: outputs compared to the model on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit f;
            logic [2:0] e;
            f = m_uf || m_win;
            e = {f && m_mode[12], f && m_mode[13] && m_mode[14], f && m_mode[13] && !m_mode[14]};
            check({fault_irq_o, rst_proc_o, rst_sys_o} == e, "R6 outputs vs model",
                  {29'd0, fault_irq_o, rst_proc_o, rst_sys_o}, {29'd0, e});
        end
    end

    task automatic bus_write(input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_sel_i = 1; bus_we_i = 1; bus_idx_i = idx; bus_wdata_i = d;
        @(negedge clk);
        bus_sel_i = 0; bus_we_i = 0; bus_wdata_i = '0;
    endtask

    task automatic bus_read(input logic [1:0] idx, output logic [31:0] d);
        @(negedge clk);
        bus_sel_i = 1; bus_we_i = 0; bus_idx_i = idx;
        #1 d = bus_rdata_o;
        @(negedge clk);
        bus_sel_i = 0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1;
        repeat (n) @(negedge clk);
        tick_i = 0;
    endtask

    task automatic read_stat(input string tag, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(2'd2, d);
        check(d == exp, tag, d, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        do_reset();

        // R1 reset state
        check({fault_irq_o, rst_proc_o, rst_sys_o} == 3'b000, "R1 outputs low", {29'd0, fault_irq_o, rst_proc_o, rst_sys_o}, 32'd0);
        bus_read(2'd1, d);
        check(d == 32'h3FFF2FFF, "R1 mode reset value", d, 32'h3FFF2FFF);
        read_stat("R1 status reset", 32'd0);

        // R2 one-time configuration: reload 40, delta 10, irq+rst+proc, both halts
        bus_write(2'd1, 32'h300A7028);
        bus_read(2'd1, d);
        check(d == 32'h300A7028, "R2 first write taken", d, 32'h300A7028);
        bus_write(2'd1, 32'h00000FFF);
        bus_read(2'd1, d);
        check(d == 32'h300A7028, "R2 second write ignored", d, 32'h300A7028);

        // R5 restart at 4095 > delta: window error, reload to 40
        bus_write(2'd0, 32'hA5000001);
        @(negedge clk);
        check(fault_irq_o && rst_proc_o && !rst_sys_o, "R6 proc scope", {29'd0, fault_irq_o, rst_proc_o, rst_sys_o}, 32'd6);
        read_stat("R5 window error flag", 32'd2);
        read_stat("R7 cleared by read", 32'd0);

        // R3 underflow timing
        ticks(40);
        read_stat("R3 no underflow at zero", 32'd0);
        ticks(1);
        read_stat("R3 underflow flag", 32'd1);

        // R4 wrong key and missing restart bit ignored
        ticks(35);
        bus_write(2'd0, 32'h5A000001);
        bus_write(2'd0, 32'hA5000000);
        ticks(5);
        read_stat("R4 bad commands ignored (no early uf)", 32'd0);
        ticks(1);
        read_stat("R4 bad commands ignored (uf on time)", 32'd1);

        // R4 R5 valid restart inside window at count 8
        ticks(32);
        bus_write(2'd0, 32'hA5000001);
        read_stat("R5 in-window restart no error", 32'd0);
        ticks(40);
        read_stat("R4 restart reloaded counter", 32'd0);

        // R7 read racing with underflow event
        @(negedge clk);
        tick_i = 1; bus_sel_i = 1; bus_we_i = 0; bus_idx_i = 2'd2;
        #1 d = bus_rdata_o;
        check(d == 32'd0, "R7 read shows pre-event value", d, 32'd0);
        @(negedge clk);
        tick_i = 0; bus_sel_i = 0;
        read_stat("R7 event wins over clear", 32'd1);

        // R8 idle halt
        ticks(40);
        idle_i = 1;
        ticks(5);
        read_stat("R8 idle freezes counter", 32'd0);
        idle_i = 0;
        ticks(1);
        read_stat("R8 counter resumes after idle", 32'd1);

        // R8 debug halt
        dbg_i = 1;
        ticks(60);
        dbg_i = 0;
        ticks(40);
        read_stat("R8 debug freezes counter", 32'd0);
        ticks(1);
        read_stat("R8 counter resumes after debug", 32'd1);

        // R10 sticky flag
        ticks(41);
        repeat (10) @(negedge clk);
        check(fault_irq_o == 1'b1, "R10 irq held", {31'd0, fault_irq_o}, 32'd1);
        read_stat("R10 flag held until read", 32'd1);
        read_stat("R10 flag gone after read", 32'd0);

        // R9 disabled watchdog
        do_reset();
        bus_write(2'd1, 32'h00009003);
        ticks(20);
        bus_write(2'd0, 32'hA5000001);
        read_stat("R9 disabled no faults", 32'd0);
        check(!fault_irq_o, "R9 irq low", {31'd0, fault_irq_o}, 32'd0);

        // R1 R5 R6 default configuration: equal-to-delta restart, system reset
        do_reset();
        bus_write(2'd0, 32'hA5000001);
        read_stat("R5 restart at delta allowed", 32'd0);
        ticks(4095);
        read_stat("R1 default no early underflow", 32'd0);
        ticks(1);
        @(negedge clk);
        check(rst_sys_o && !rst_proc_o && !fault_irq_o, "R6 system scope",
              {29'd0, fault_irq_o, rst_proc_o, rst_sys_o}, 32'd1);
        read_stat("R3 default underflow", 32'd1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule